// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the software-visible control store for one general purpose I/O port of up to 32 pins. A simple word-wide bus writes and reads it. The bus has a select, a write strobe, a 12-bit byte address and 32-bit data. Write data is captured on the rising clock edge. Read data is combinational from the current register state.

The block holds three kinds of state: the port output value, the port direction, and one configuration word per pin. The output value and the direction each have two extra addresses. Writing a 1 to one of these sets or clears the matching bit, and reading it returns the underlying register. Bit 0 of each pin's configuration word is the same storage as that pin's direction bit.

From this state the block drives each pad's output level, output enable, pull-up, pull-down and input-buffer enable. It also returns pad input levels through a two-flop synchronizer. The drive field of the configuration word can leave one logic level undriven, which supports wired-OR and wired-AND buses. Level sensing and latching are done by a separate block; this block only stores the sense field.

Top module: `pio_bank`

## Requirements
- R1: After reset:
  - the output register and the direction register read 0;
  - every configuration word reads 0x00000002;
  - every pad output enable and every input-buffer enable is 0.
- R2: A write to offset 0x504 replaces the whole output register. Reads of 0x504 return it, and pad_out follows it.
- R3: A write to 0x508 sets the output bits written as 1, and a write to 0x50C clears them. Bits written as 0 are unchanged. Reads of either offset return the output register.
- R4: The direction register is at 0x514 (1 = output). A write to 0x518 sets the bits written as 1, and a write to 0x51C clears them. Reads of all three offsets return the direction register.
- R5: The configuration word of pin n is at 0x700 + 4·n. Its bit 0 is the same storage as direction bit n, so a write through either address is visible through both.
- R6: Configuration bit 1 set disconnects the input buffer: pad_ie is 0 and that pin's bit at offset 0x510 reads 0. Bit 1 clear gives pad_ie 1.
- R7: Offset 0x510 returns the pad input levels through two register stages. A pad change applied before a clock edge is not visible after that edge, and is visible after the next edge.
- R8: Configuration bits 3:2 select the pull:
  - 1 drives pad_pd only;
  - 3 drives pad_pu only;
  - 0 and 2 drive neither.
- R9: Configuration bits 10:8 select the drive mode, and the output enable is 0 while the pin is an input:
  - codes 0 to 3 enable the output for both levels;
  - codes 4 and 5 enable it only while the output bit is 1;
  - codes 6 and 7 enable it only while the output bit is 0.
- R10: Configuration bits 17:16 (the sense field) are stored and read back. All other configuration bits are ignored on write and read as 0, so writing 0xFFFFFFFF reads back 0x0003070F.
- R11: Writes to 0x510, to unmapped offsets and to addresses with bits 1:0 non-zero change no state. Such reads return 0, except that 0x510 returns the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pad_in | input | NPINS | Raw pad input levels |
| pad_out | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad output enables |
| pad_pu | output | NPINS | Pull-up enables |
| pad_pd | output | NPINS | Pull-down enables |
| pad_ie | output | NPINS | Input-buffer enables |

## Verification
The hardest case to reach is a pad driven for one level only. The output enable then depends jointly on direction, output value and drive code, and these are written through three different addresses. The stimulus therefore walks a single pin through each drive class and toggles the output through the set and clear aliases in between. The output enable is checked after every step, and the pin is finally made an input again through its configuration word.

The synchronizer latency is checked by changing the pads at a falling edge and reading the input register after one rising edge and then after two.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    // Word offsets of the port registers.
    localparam logic [ADDR_W-1:0] OFF_OUT    = 12'h504;
    localparam logic [ADDR_W-1:0] OFF_OUTSET = 12'h508;
    localparam logic [ADDR_W-1:0] OFF_OUTCLR = 12'h50C;
    localparam logic [ADDR_W-1:0] OFF_IN     = 12'h510;
    localparam logic [ADDR_W-1:0] OFF_DIR    = 12'h514;
    localparam logic [ADDR_W-1:0] OFF_DIRSET = 12'h518;
    localparam logic [ADDR_W-1:0] OFF_DIRCLR = 12'h51C;

    // The configuration window occupies 0x700..0x77C, so address bits 11:7 equal 5'b01110.
    localparam logic [4:0] CFG_PAGE = 5'b01110;

    // Per-pin configuration fields held outside the direction register.
    typedef struct packed {
        logic       buf_off;   // word bit 1
        logic [1:0] pull;      // word bits 3:2
        logic [2:0] drive;     // word bits 10:8
        logic [1:0] sense;     // word bits 17:16
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{buf_off: 1'b1, pull: 2'd0, drive: 3'd0, sense: 2'd0};

    function automatic pin_cfg_t cfg_unpack(input logic [DATA_W-1:0] w);
        pin_cfg_t c;
        c.buf_off = w[1];
        c.pull    = w[3:2];
        c.drive   = w[10:8];
        c.sense   = w[17:16];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_pack(input pin_cfg_t c, input logic dir);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[0]     = dir;
        w[1]     = c.buf_off;
        w[3:2]   = c.pull;
        w[10:8]  = c.drive;
        w[17:16] = c.sense;
        return w;
    endfunction

    // Drive-mode classes: which levels the driver actively produces.
    function automatic logic drives_high(input logic [2:0] drv);
        return !(drv[2] && drv[1]);
    endfunction

    function automatic logic drives_low(input logic [2:0] drv);
        return !(drv[2] && !drv[1]);
    endfunction

endpackage

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
        logic [1:0]   warm;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = din;
        st_d.sync = st_q.meta;
        if (st_q.warm != 2'd2) begin
            st_d.warm = st_q.warm + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.sync;

    // R7: output equals the input from exactly two edges earlier
    p_two_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm == 2'd2) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/pio_pin_ctrl.sv
module pio_pin_ctrl
    import pio_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_we,
    input  pin_cfg_t cfg_wr,
    input  logic     dir,
    input  logic     out,
    output pin_cfg_t cfg,
    output logic     pad_oe,
    output logic     pad_pu,
    output logic     pad_pd,
    output logic     pad_ie
);
    pin_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d = cfg_wr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    logic lvl_driven;

    always_comb begin
        lvl_driven = out ? drives_high(cfg_q.drive) : drives_low(cfg_q.drive);
        pad_oe     = dir && lvl_driven;
        pad_pu     = (cfg_q.pull == 2'd3);
        pad_pd     = (cfg_q.pull == 2'd1);
        pad_ie     = !cfg_q.buf_off;
    end

    assign cfg = cfg_q;

    p_pull_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pad_pu && pad_pd));

    p_oe_needs_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe |-> dir);

    p_buf_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (pad_ie == !$past(cfg_wr.buf_off)));

endmodule

// File: rtl/pio_bank.sv
module pio_bank
    import pio_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pu,
    output logic [NPINS-1:0]  pad_pd,
    output logic [NPINS-1:0]  pad_ie
);
    localparam int IDX_W = 5;

    typedef struct packed {
        logic [NPINS-1:0] out;
        logic [NPINS-1:0] dir;
    } port_st_t;

    port_st_t st_d, st_q;

    logic             aligned, wr_en;
    logic             cfg_hit;
    logic [IDX_W-1:0] cfg_idx;
    logic [NPINS-1:0] cfg_we;
    logic [NPINS-1:0] in_sync;
    logic [NPINS-1:0] wmask;
    pin_cfg_t         cfg_wr;
    pin_cfg_t         pin_cfg [NPINS];

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_en   = bus_sel && bus_wr && aligned;
    assign cfg_hit = aligned && (bus_addr[11:7] == CFG_PAGE);
    assign cfg_idx = bus_addr[6:2];
    assign cfg_wr  = cfg_unpack(bus_wdata);
    assign wmask   = bus_wdata[NPINS-1:0];

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            cfg_we[i] = wr_en && cfg_hit && (cfg_idx == IDX_W'(i));
        end
    end

    // Next state for output and direction.
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (bus_addr)
                OFF_OUT:    st_d.out = wmask;
                OFF_OUTSET: st_d.out = st_q.out | wmask;
                OFF_OUTCLR: st_d.out = st_q.out & ~wmask;
                OFF_DIR:    st_d.dir = wmask;
                OFF_DIRSET: st_d.dir = st_q.dir | wmask;
                OFF_DIRCLR: st_d.dir = st_q.dir & ~wmask;
                default:    ;
            endcase
        end
        for (int i = 0; i < NPINS; i++) begin
            if (cfg_we[i]) begin
                st_d.dir[i] = bus_wdata[0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    pio_in_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pad_in),
        .dout  (in_sync)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        pio_pin_ctrl u_pin (
            .clk    (clk),
            .rst_n  (rst_n),
            .cfg_we (cfg_we[g]),
            .cfg_wr (cfg_wr),
            .dir    (st_q.dir[g]),
            .out    (st_q.out[g]),
            .cfg    (pin_cfg[g]),
            .pad_oe (pad_oe[g]),
            .pad_pu (pad_pu[g]),
            .pad_pd (pad_pd[g]),
            .pad_ie (pad_ie[g])
        );
    end

    assign pad_out = st_q.out;

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (bus_addr)
                OFF_OUT, OFF_OUTSET, OFF_OUTCLR: bus_rdata[NPINS-1:0] = st_q.out;
                OFF_DIR, OFF_DIRSET, OFF_DIRCLR: bus_rdata[NPINS-1:0] = st_q.dir;
                OFF_IN:                          bus_rdata[NPINS-1:0] = in_sync & pad_ie;
                default: begin
                    if (cfg_hit) begin
                        for (int i = 0; i < NPINS; i++) begin
                            if (cfg_idx == IDX_W'(i)) begin
                                bus_rdata = cfg_pack(pin_cfg[i], st_q.dir[i]);
                            end
                        end
                    end
                end
            endcase
        end
    end

    p_out_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == OFF_OUT) |=> (pad_out == $past(wmask)));

    p_outset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == OFF_OUTSET) |=> (pad_out == ($past(pad_out) | $past(wmask))));

    p_outclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == OFF_OUTCLR) |=> (pad_out == ($past(pad_out) & ~$past(wmask))));

    p_dirset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == OFF_DIRSET) |=> (st_q.dir == ($past(st_q.dir) | $past(wmask))));

    p_dirclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == OFF_DIRCLR) |=> (st_q.dir == ($past(st_q.dir) & ~$past(wmask))));

    p_cfg_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg_hit && cfg_idx == 5'd0) |=> (st_q.dir[0] == $past(bus_wdata[0])));

    p_in_ro_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (bus_addr == OFF_IN || !aligned)) |=> $stable(st_q));

endmodule

// File: tb/sim_pio_bank.sv
`timescale 1ns/1ps
module sim_pio_bank;
    localparam int NPINS = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NPINS-1:0]  pad_in = '0;
    logic [NPINS-1:0]  pad_out, pad_oe, pad_pu, pad_pd, pad_ie;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pio_bank #(.NPINS(NPINS)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_ie(pad_ie)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;   // write data, or expected read data
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 12'h504, 32'hA5A5_0F0F, 8'd2},   // R2 full write
        '{1'b0, 12'h504, 32'hA5A5_0F0F, 8'd2},   // R2
        '{1'b1, 12'h508, 32'h0000_F000, 8'd3},   // R3 set alias
        '{1'b0, 12'h504, 32'hA5A5_FF0F, 8'd3},   // R3
        '{1'b1, 12'h50C, 32'hA000_0001, 8'd3},   // R3 clear alias
        '{1'b0, 12'h50C, 32'h05A5_FF0E, 8'd3},   // R3 alias read
        '{1'b0, 12'h508, 32'h05A5_FF0E, 8'd3},   // R3 alias read
        '{1'b1, 12'h514, 32'h0000_00F0, 8'd4},   // R4
        '{1'b1, 12'h518, 32'h8000_0001, 8'd4},   // R4 set alias
        '{1'b0, 12'h51C, 32'h8000_00F1, 8'd4},   // R4 alias read
        '{1'b1, 12'h51C, 32'h0000_0030, 8'd4},   // R4 clear alias
        '{1'b0, 12'h514, 32'h8000_00C1, 8'd4},   // R4
        '{1'b0, 12'h700, 32'h0000_0003, 8'd5},   // R5 dir seen in cfg 0
        '{1'b0, 12'h714, 32'h0000_0002, 8'd5},   // R5 cfg 5
        '{1'b0, 12'h77C, 32'h0000_0003, 8'd5},   // R5 cfg 31
        '{1'b1, 12'h714, 32'hFFFF_FFFF, 8'd10},  // R10 reserved bits
        '{1'b0, 12'h714, 32'h0003_070F, 8'd10},  // R10
        '{1'b0, 12'h514, 32'h8000_00E1, 8'd5},   // R5 cfg write seen in dir
        '{1'b1, 12'h600, 32'hFFFF_FFFF, 8'd11},  // R11 unmapped write
        '{1'b0, 12'h600, 32'h0000_0000, 8'd11}   // R11 unmapped read
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic read_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        bus_read(a, d);
        chk(d == exp, tag, d, exp);
    endtask

    task automatic bit_chk(input logic act, input logic exp, input string tag);
        chk(act == exp, tag, {31'd0, act}, {31'd0, exp});
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_chk(12'h504, 32'h0, "R1 out");
        read_chk(12'h514, 32'h0, "R1 dir");
        read_chk(12'h71C, 32'h2, "R1 cfg7");
        chk(pad_oe == '0, "R1 pad_oe", pad_oe, 32'h0);
        chk(pad_ie == '0, "R1 pad_ie", pad_ie, 32'h0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i].wr) begin
                bus_write(VEC[i].addr, VEC[i].data);
            end else begin
                bus_read(VEC[i].addr, d);
                chk(d == VEC[i].data, $sformatf("R%0d vec%0d", VEC[i].req, i), d, VEC[i].data);
            end
        end
        chk(pad_out == 32'h05A5_FF0E, "R2 pad_out", pad_out, 32'h05A5_FF0E);

        // R9 drive classes on pin 2 (out bit 2 is 1 here)
        bus_write(12'h708, 32'h0000_0401);                 // output, high-only
        bit_chk(pad_oe[2], 1'b1, "R9 high-only out1");
        bus_write(12'h50C, 32'h4);
        bit_chk(pad_oe[2], 1'b0, "R9 high-only out0");
        bus_write(12'h708, 32'h0000_0601);                 // low-only
        bit_chk(pad_oe[2], 1'b1, "R9 low-only out0");
        bus_write(12'h508, 32'h4);
        bit_chk(pad_oe[2], 1'b0, "R9 low-only out1");
        bus_write(12'h708, 32'h0000_0301);                 // both levels
        bit_chk(pad_oe[2], 1'b1, "R9 both out1");
        bit_chk(pad_out[2], 1'b1, "R2 pad_out bit2");
        bus_write(12'h708, 32'h0000_0300);                 // input via cfg bit 0
        bit_chk(pad_oe[2], 1'b0, "R9 input");
        read_chk(12'h514, 32'h8000_00E1, "R5 dir bit2 cleared by cfg");

        // R8 pull field on pin 3
        bus_write(12'h70C, 32'h4);
        bit_chk(pad_pd[3], 1'b1, "R8 pd code1");
        bit_chk(pad_pu[3], 1'b0, "R8 pu code1");
        bus_write(12'h70C, 32'hC);
        bit_chk(pad_pu[3], 1'b1, "R8 pu code3");
        bit_chk(pad_pd[3], 1'b0, "R8 pd code3");
        bus_write(12'h70C, 32'h8);
        bit_chk(pad_pu[3] | pad_pd[3], 1'b0, "R8 code2 none");

        // R6 / R7 input path on pin 9 (connected) and pin 5 (disconnected)
        bus_write(12'h724, 32'h0);
        bit_chk(pad_ie[9], 1'b1, "R6 ie connected");
        bit_chk(pad_ie[5], 1'b0, "R6 ie disconnected");
        @(negedge clk);
        pad_in = '1;
        @(posedge clk);
        #2;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h510;
        #1;
        bit_chk(bus_rdata[9], 1'b0, "R7 one edge");
        @(posedge clk);
        #2;
        bit_chk(bus_rdata[9], 1'b1, "R7 two edges");
        bit_chk(bus_rdata[5], 1'b0, "R6 in masked");
        bus_sel = 1'b0;

        // R11 writes to IN and unaligned addresses are ignored
        bus_write(12'h510, 32'h0);
        bus_write(12'h506, 32'h0);
        read_chk(12'h504, 32'h05A5_FF0E, "R11 out unchanged");
        bus_read(12'h510, d);
        bit_chk(d[9], 1'b1, "R11 in still live");
        read_chk(12'h516, 32'h0, "R11 unaligned read");

        // R5 clear direction through cfg 31
        bus_write(12'h77C, 32'h2);
        read_chk(12'h518, 32'h0000_00E1, "R5 dir31 via cfg");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule